// File: doc/BRIEF.md
# Four-Bank Selectable Clock Divider with Feedback Output

This block takes one fast source clock and drives four banks of clock outputs plus one feedback output. Each bank has its own 2-bit ratio select and its own drive enable. The four outputs inside a bank always carry the same waveform. The feedback output has a separate divider with a different set of ratios.

A mode input picks between two sources for every output. In divided mode the outputs come from the dividers. In pass-through mode they carry a reference level, taken from one of two reference inputs chosen by a source select. A synchronous master clear stops all dividers and holds every driven output low. When the clear is lifted, all dividers restart on the same source edge. Each output is modelled as a data bit plus a per-bank drive flag rather than as a real tri-state pin.

The ratios are divide-by-3, 4, 6 and 12 for the banks and divide-by-6, 12, 16 and 20 for feedback. Divide-by-3 uses a half-period stretch so that its duty stays at 50%. A new ratio select is adopted only when the divider wraps, so a change never produces a short pulse.

Top module: `cdiv_fanout`

## Requirements
- R1: Bank ratio select (2 bits per bank, bank b at bits 2b+1:2b) maps 0 to divide-by-3, 1 to divide-by-4, 2 to divide-by-6 and 3 to divide-by-12. The output period equals that many source cycles.
- R2: Feedback ratio select maps 0 to divide-by-6, 1 to divide-by-12, 2 to divide-by-16 and 3 to divide-by-20.
- R3: For even ratios the output is high for exactly half the period, starting at a source rising edge.
- R4: For divide-by-3 the output is high for 1.5 source cycles out of 3: from one rising edge to the falling edge of the next cycle.
- R5: The outputs of a bank (bank b at bank_clk bits 4b+3:4b) always hold identical values.
- R6: While master clear is high, every output is low. After master clear is sampled low at a rising edge, every bank output and the feedback output go high together just after the next rising edge.
- R7: A low bank enable clears that bank's drive flag and forces its data bits low. This holds whether or not master clear is high. A high bank enable sets the drive flag.
- R8: With mode low (pass-through) and master clear sampled low at the previous edge, every enabled output and the feedback output follow the selected reference level.
- R9: Source select high picks xtal_in as the pass-through reference. Source select low picks ref_in.
- R10: A ratio select change is adopted only when the running period ends. The period in progress completes at the old ratio, and the next period uses the new one.
- R11: While rst_n is low, all data outputs are low and each drive flag equals its bank enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr | input | 1 | Master clear, active high, synchronous |
| pll_mode | input | 1 | 1 = divided outputs, 0 = pass-through |
| ref_src_sel | input | 1 | 1 = xtal_in, 0 = ref_in for pass-through |
| xtal_in | input | 1 | Oscillator reference level |
| ref_in | input | 1 | External reference level |
| bank_sel | input | 2*BANKS | Ratio select per bank |
| fb_sel | input | 2 | Feedback ratio select |
| bank_oe | input | BANKS | Drive enable per bank |
| bank_clk | output | BANKS*FANOUT | Bank output data bits |
| bank_drv | output | BANKS | Drive flag per bank (0 = high impedance) |
| fb_clk | output | 1 | Feedback output |

## Verification
A corrupted counter or a latched ratio register shows at the ports as a wrong period or high time. This is visible within one output period, at most 20 source cycles. A run flag that is out of step shows on the first source edge after master clear falls: one of the seventeen outputs either fails to rise with the others or rises one edge late. A broken falling-edge stretch stage leaves the divide-by-3 high time at one full cycle instead of one and a half, so the bench samples at every half cycle. A ratio register loaded outside the wrap point produces a short period right after the select change.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int RATIO_W = 5;
  typedef logic [1:0] div_sel_t;

  function automatic logic [RATIO_W-1:0] path_ratio(input logic is_fb, input div_sel_t s);
    logic [RATIO_W-1:0] r;
    if (is_fb) begin
      case (s)
        2'd0: r = RATIO_W'(6);
        2'd1: r = RATIO_W'(12);
        2'd2: r = RATIO_W'(16);
        default: r = RATIO_W'(20);
      endcase
    end else begin
      case (s)
        2'd0: r = RATIO_W'(3);
        2'd1: r = RATIO_W'(4);
        2'd2: r = RATIO_W'(6);
        default: r = RATIO_W'(12);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/cdiv_divider.sv
module cdiv_divider
  import cdiv_pkg::*;
#(
  parameter bit IS_FB = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  div_sel_t sel_i,
  output logic     div_o
);
  div_sel_t           act_q, act_d;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio, half;
  logic               wrap, pos_lvl, neg_q, neg_d;

  // next state: ratio register reloads only while stopped or at the wrap
  always_comb begin
    ratio   = path_ratio(IS_FB, act_q);
    half    = ratio >> 1;
    wrap    = (cnt_q == ratio - RATIO_W'(1));
    pos_lvl = (cnt_q < half);
    act_d   = act_q;
    cnt_d   = cnt_q;
    if (!run_i || wrap) begin
      cnt_d = '0;
      act_d = sel_i;
    end else begin
      cnt_d = cnt_q + RATIO_W'(1);
    end
    // falling-edge stretch only for odd ratios
    neg_d = run_i & pos_lvl & ratio[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= neg_d;
  end

  assign div_o = run_i & (pos_lvl | neg_q);
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank #(
  parameter int FANOUT = 4
) (
  input  logic              div_i,
  input  logic              byp_i,
  input  logic              pll_mode,
  input  logic              run_i,
  input  logic              oe_i,
  output logic [FANOUT-1:0] q_o,
  output logic              drv_o
);
  logic lvl;

  always_comb begin
    lvl = oe_i & run_i & (pll_mode ? div_i : byp_i);
  end

  for (genvar i = 0; i < FANOUT; i++) begin : g_fan
    assign q_o[i] = lvl;
  end

  assign drv_o = oe_i;
endmodule

// File: rtl/cdiv_fanout.sv
module cdiv_fanout
  import cdiv_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int FANOUT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mr,
  input  logic                      pll_mode,
  input  logic                      ref_src_sel,
  input  logic                      xtal_in,
  input  logic                      ref_in,
  input  logic [2*BANKS-1:0]        bank_sel,
  input  logic [1:0]                fb_sel,
  input  logic [BANKS-1:0]          bank_oe,
  output logic [BANKS*FANOUT-1:0]   bank_clk,
  output logic [BANKS-1:0]          bank_drv,
  output logic                      fb_clk
);
  localparam int NOUT = BANKS * FANOUT;

  logic             run_q, run_d;
  logic             byp_lvl;
  logic [BANKS-1:0] bank_div;
  logic             fb_div;

  always_comb begin
    run_d   = ~mr;
    byp_lvl = ref_src_sel ? xtal_in : ref_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    cdiv_divider #(.IS_FB(1'b0)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run_q),
      .sel_i (bank_sel[2*b +: 2]),
      .div_o (bank_div[b])
    );
    cdiv_bank #(.FANOUT(FANOUT)) u_bank (
      .div_i    (bank_div[b]),
      .byp_i    (byp_lvl),
      .pll_mode (pll_mode),
      .run_i    (run_q),
      .oe_i     (bank_oe[b]),
      .q_o      (bank_clk[b*FANOUT +: FANOUT]),
      .drv_o    (bank_drv[b])
    );
  end

  cdiv_divider #(.IS_FB(1'b1)) u_fbdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run_q),
    .sel_i (fb_sel),
    .div_o (fb_div)
  );

  assign fb_clk = run_q & (pll_mode ? fb_div : byp_lvl);

  logic unused_nout;
  assign unused_nout = (NOUT == 0);
endmodule

// File: rtl/cdiv_fanout_chk.sv
module cdiv_fanout_chk #(
  parameter int BANKS  = 4,
  parameter int FANOUT = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mr,
  input logic                    pll_mode,
  input logic                    ref_src_sel,
  input logic                    xtal_in,
  input logic                    ref_in,
  input logic [BANKS-1:0]        bank_oe,
  input logic [BANKS*FANOUT-1:0] bank_clk,
  input logic                    fb_clk
);
  logic [BANKS*FANOUT-1:0] oe_wide;

  always_comb begin
    for (int i = 0; i < BANKS*FANOUT; i++) oe_wide[i] = bank_oe[i / FANOUT];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_same
    AST_BANK_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_clk[b*FANOUT +: FANOUT] == '0) || (bank_clk[b*FANOUT +: FANOUT] == '1)); // R5
  end

  AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mr) |-> (bank_clk == '0) && !fb_clk); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_clk & ~oe_wide) == '0)); // R7

  AST_PASS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_mode && !$past(mr) && !ref_src_sel) |-> (fb_clk == ref_in)); // R8

  AST_PASS_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_mode && !$past(mr) && ref_src_sel) |-> (fb_clk == xtal_in)); // R9
endmodule

bind cdiv_fanout cdiv_fanout_chk #(.BANKS(BANKS), .FANOUT(FANOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mr          (mr),
  .pll_mode    (pll_mode),
  .ref_src_sel (ref_src_sel),
  .xtal_in     (xtal_in),
  .ref_in      (ref_in),
  .bank_oe     (bank_oe),
  .bank_clk    (bank_clk),
  .fb_clk      (fb_clk)
);

// File: tb/cdiv_fanout_test.sv
module cdiv_fanout_test;
  localparam int CLK_P  = 10;
  localparam int BANKS  = 4;
  localparam int FANOUT = 4;

  // {bank A select, feedback select, bank A ratio, feedback ratio}
  localparam logic [13:0] VEC [16] = '{
    {2'd0, 2'd0, 5'd3,  5'd6 }, {2'd0, 2'd1, 5'd3,  5'd12},
    {2'd0, 2'd2, 5'd3,  5'd16}, {2'd0, 2'd3, 5'd3,  5'd20},
    {2'd1, 2'd0, 5'd4,  5'd6 }, {2'd1, 2'd1, 5'd4,  5'd12},
    {2'd1, 2'd2, 5'd4,  5'd16}, {2'd1, 2'd3, 5'd4,  5'd20},
    {2'd2, 2'd0, 5'd6,  5'd6 }, {2'd2, 2'd1, 5'd6,  5'd12},
    {2'd2, 2'd2, 5'd6,  5'd16}, {2'd2, 2'd3, 5'd6,  5'd20},
    {2'd3, 2'd0, 5'd12, 5'd6 }, {2'd3, 2'd1, 5'd12, 5'd12},
    {2'd3, 2'd2, 5'd12, 5'd16}, {2'd3, 2'd3, 5'd12, 5'd20}
  };

  logic clk, rst_n, mr, pll_mode, ref_src_sel, xtal_in, ref_in;
  logic [2*BANKS-1:0]        bank_sel;
  logic [1:0]                fb_sel;
  logic [BANKS-1:0]          bank_oe;
  logic [BANKS*FANOUT-1:0]   bank_clk;
  logic [BANKS-1:0]          bank_drv;
  logic                      fb_clk;

  int n_chk = 0;
  int n_bad = 0;

  cdiv_fanout #(.BANKS(BANKS), .FANOUT(FANOUT)) uut (
    .clk(clk), .rst_n(rst_n), .mr(mr), .pll_mode(pll_mode),
    .ref_src_sel(ref_src_sel), .xtal_in(xtal_in), .ref_in(ref_in),
    .bank_sel(bank_sel), .fb_sel(fb_sel), .bank_oe(bank_oe),
    .bank_clk(bank_clk), .bank_drv(bank_drv), .fb_clk(fb_clk)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic int bank_ratio(input logic [1:0] s);
    case (s)
      2'd0: return 3;
      2'd1: return 4;
      2'd2: return 6;
      default: return 12;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance to 2 time units after the next clock edge of either polarity
  task automatic hstep();
    @(posedge clk or negedge clk);
    #2;
  endtask

  function automatic logic out_bit(input int w);
    return (w < BANKS) ? bank_clk[w*FANOUT] : fb_clk;
  endfunction

  // period and high time in half source cycles
  task automatic measure(input int w, output int per, output int hi);
    int lo;
    hi = 0; lo = 0;
    while (out_bit(w) !== 1'b0) hstep();
    while (out_bit(w) !== 1'b1) hstep();
    while (out_bit(w) === 1'b1) begin hi++; hstep(); end
    while (out_bit(w) === 1'b0) begin lo++; hstep(); end
    per = hi + lo;
  endtask

  // apply master clear, release it and check the common first edge
  task automatic restart(input string req);
    @(posedge clk); #2 mr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2 mr = 1'b0;
    check({req, " low before release edge"}, int'(bank_clk == '0 && !fb_clk), 1);
    @(posedge clk); #2;
    check({req, " all rise together"}, int'(bank_clk == '1 && fb_clk), 1);
  endtask

  initial begin
    rst_n = 1'b0; mr = 1'b0; pll_mode = 1'b1; ref_src_sel = 1'b0;
    xtal_in = 1'b0; ref_in = 1'b0; bank_sel = '0; fb_sel = '0;
    bank_oe = 4'b1011;
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state
    check("R11 data low in reset", int'(bank_clk), 0);
    check("R11 fb low in reset", int'(fb_clk), 0);
    check("R11 drive flags follow enable", int'(bank_drv), int'(4'b1011));
    bank_oe = '1;
    @(negedge clk); #2 rst_n = 1'b1;

    // table walk over all 16 bank/feedback select pairs
    for (int v = 0; v < 16; v++) begin
      logic [1:0] bs;
      int per, hi, n;
      bs = VEC[v][13:12];
      for (int b = 0; b < BANKS; b++) bank_sel[2*b +: 2] = bs + 2'(b);
      fb_sel = VEC[v][11:10];
      restart("R6");
      for (int b = 0; b < BANKS; b++) begin
        n = (b == 0) ? int'(VEC[v][9:5]) : bank_ratio(bs + 2'(b));
        measure(b, per, hi);
        check($sformatf("R1 bank %0d period (half cycles)", b), per, 2*n);
        check((n % 2 == 1) ? "R4 odd ratio high time" : "R3 even ratio high time", hi, n);
      end
      n = int'(VEC[v][4:0]);
      measure(BANKS, per, hi);
      check("R2 feedback period (half cycles)", per, 2*n);
      check("R3 feedback high time", hi, n);
      // R5: bank lanes identical across a window
      begin
        int odd_lanes;
        odd_lanes = 0;
        for (int k = 0; k < 24; k++) begin
          for (int b = 0; b < BANKS; b++)
            if (bank_clk[b*FANOUT +: FANOUT] != '0 && bank_clk[b*FANOUT +: FANOUT] != '1)
              odd_lanes++;
          hstep();
        end
        check("R5 lanes within bank identical", odd_lanes, 0);
      end
    end

    // R10: select change mid-period, bank A divide-by-12 then divide-by-3
    begin
      int bad;
      bad = 0;
      bank_sel[1:0] = 2'd3;
      @(posedge clk); #2 mr = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); #2 mr = 1'b0;
      @(posedge clk); #2;
      for (int h = 0; h < 60; h++) begin
        logic e;
        e = (h < 24) ? (h < 12) : (((h - 24) % 6) < 3);
        if (bank_clk[0] !== e) bad++;
        if (h == 4) bank_sel[1:0] = 2'd0;
        hstep();
      end
      check("R10 old period completes before new ratio", bad, 0);
    end

    // R7: disabled bank quiet while others run, and priority over clear
    begin
      int seen_hi, other_hi;
      seen_hi = 0; other_hi = 0;
      bank_oe = 4'b1011;
      for (int k = 0; k < 30; k++) begin
        if (bank_clk[8 +: 4] != '0) seen_hi++;
        if (bank_clk[0]) other_hi++;
        hstep();
      end
      check("R7 disabled bank data low", seen_hi, 0);
      check("R7 disabled bank drive flag", int'(bank_drv), int'(4'b1011));
      check("R7 enabled bank still toggles", int'(other_hi > 0), 1);
      @(posedge clk); #2 mr = 1'b1;
      repeat (2) @(posedge clk); #2;
      check("R7 clear high, disabled flag stays off", int'(bank_drv[2]), 0);
      check("R7 clear high, enabled flag on", int'(bank_drv[0]), 1);
      check("R6 clear high, data low", int'(bank_clk), 0);
      bank_oe = '1;
      @(negedge clk); #2 mr = 1'b0;
      @(posedge clk); #2;
    end

    // R8 / R9: pass-through mode
    pll_mode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic r, x;
      r = k[0]; x = ~k[0];
      ref_src_sel = 1'b0; ref_in = r; xtal_in = x;
      #1;
      check("R8 pass-through follows ref_in", int'(bank_clk), r ? int'({16{1'b1}}) : 0);
      check("R8 feedback follows ref_in", int'(fb_clk), int'(r));
      ref_src_sel = 1'b1;
      #1;
      check("R9 source select picks xtal_in", int'(bank_clk), x ? int'({16{1'b1}}) : 0);
      hstep();
    end
    mr = 1'b1; ref_in = 1'b1; ref_src_sel = 1'b0;
    repeat (2) @(posedge clk); #2;
    check("R6 clear overrides pass-through", int'(fb_clk), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule